// File: doc/BRIEF.md
# Hot-Plug Slot Controller

This block holds the slot control and slot status registers of a hot-plug capable downstream port. Configuration writes reach it through two strobes, one for the control register and one for the status register, each with its own 16-bit data word. Slot events come in on single-cycle pulses:
- a hot insertion request,
- a removal request,
- a cold-plug marker for a device present at power-up,
- the attention button.

The block keeps the event status bits and tracks whether the device is present. It also drives the electromechanical interlock status.

One notify condition is derived from the registers. It is the hot-plug interrupt enable ANDed with any event status bit whose enable is also set. A new notification goes out only when this condition changes value. With message-signalled interrupts enabled, the block emits a one-cycle request that carries the interrupt vector number and a flag that picks the extended message scheme over plain messages. With neither enabled, a level INTx line follows the condition.

Control register layout:

| Bits | Field |
|------|-------|
| 0 | button-event enable |
| 3 | presence-change enable |
| 4 | command-done enable |
| 5 | hot-plug interrupt enable |
| 7:6 | attention indicator |
| 9:8 | power indicator |
| 11 | interlock control |

Status register layout:

| Bit | Field |
|-----|-------|
| 0 | button pressed |
| 3 | presence changed |
| 4 | command done |
| 6 | presence state |
| 7 | interlock engaged |

Top module: `hp_slot_ctl`

## Requirements
- R1: After reset the control register reads 16'h03C0, with both indicators at Off (2'b11) and every other field 0. The status register reads 0, and intx, msg_req and busy are 0.
- R2: A cold_plug pulse sets presence state (status bit 6) and leaves presence changed (bit 3) clear. It triggers no notification.
- R3: A control write stores only bits 0, 3, 4, 5 and 9:6. Interlock control (bit 11) and all other bits always read 0.
- R4: Every control write sets command done (status bit 4) in the same cycle it is taken.
- R5: A control write with bit 11 set inverts interlock engaged (status bit 7). Writing 0 to bit 11 leaves bit 7 unchanged.
- R6: The notify condition is bit 5 of control ANDed with the OR over bits {0,3,4} of (status AND control). In INTx mode, intx takes the new value of the condition one cycle after an evaluation that finds it changed.
- R7: While interlock engaged is 1, plug_req and unplug_req are refused. busy pulses in the next cycle and status is unchanged.
- R8: A status write clears each of bits 0, 3 and 4 whose data bit is 1, and leaves the other status bits alone. It re-reads the condition without sending a message. In INTx mode, if the condition is false, intx drops one cycle later.
- R9: An accepted plug_req sets presence state and presence changed. An accepted unplug_req clears presence state and sets presence changed.
- R10: A message request is issued only when an evaluation finds the condition changed. This covers both rising and falling changes. msg_vec carries msg_num. msg_is_msix is 1 when msix_en is set, even if msi_en is also set. msg_is_msix is 0 when only msi_en is set. intx never rises in a message mode.
- R11: btn_press sets button pressed (status bit 0). Setting an event bit that is already 1 starts no evaluation and no message.
- R12: With hot-plug interrupt enable (control bit 5) clear, no enabled event asserts intx or sends a message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe hitting slot control |
| ctl_wdata | input | 16 | Slot control write data |
| sts_wr | input | 1 | Write strobe hitting slot status |
| sts_wdata | input | 16 | Slot status write data (ones clear events) |
| plug_req | input | 1 | Hot insertion request pulse |
| unplug_req | input | 1 | Removal request pulse |
| cold_plug | input | 1 | Device present at power-up marker |
| btn_press | input | 1 | Attention button pulse |
| msix_en | input | 1 | Extended message interrupts enabled |
| msi_en | input | 1 | Message interrupts enabled |
| msg_num | input | 5 | Interrupt vector number |
| ctl_rd | output | 16 | Slot control read value |
| sts_rd | output | 16 | Slot status read value |
| busy | output | 1 | Plug or unplug refused, one-cycle pulse |
| msg_req | output | 1 | Message interrupt request pulse |
| msg_vec | output | 5 | Vector carried with msg_req |
| msg_is_msix | output | 1 | Request uses the extended scheme |
| intx | output | 1 | Level interrupt line |

## Verification
The bench goes after the change-only rule in both directions.
- A button press while the condition is already true must stay silent. A design that re-sent on every evaluation would produce an extra message.
- Dropping the interrupt enable must still send a message for the falling change. A design that sent only on rising changes would lose that item from the scoreboard.

Further cases target specific wrong designs:
- Interlock toggling is applied twice, so that a design which set the bit instead of inverting it leaves the slot locked. The refused plug then shows up through busy and an unchanged presence state.
- A status write that clears the last enabled event in INTx mode must drop intx. A design with a stuck line fails here.
- Both message enables are raised together, which catches a reversed priority through msg_is_msix.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int REG_W = 16;
  // status bit positions
  localparam int ST_BTN  = 0;
  localparam int ST_PCHG = 3;
  localparam int ST_CDON = 4;
  localparam int ST_PRES = 6;
  localparam int ST_LOCK = 7;
  // control bit positions
  localparam int CT_HPIE = 5;
  localparam int CT_LCTL = 11;
  localparam logic [REG_W-1:0] EVT_MASK  = 16'h0019;
  localparam logic [REG_W-1:0] CTL_WMASK = 16'h03F9;
  localparam logic [REG_W-1:0] CTL_RST   = 16'h03C0;
endpackage

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
  import hp_slot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [REG_W-1:0] ctl_wdata,
  input  logic             sts_wr,
  input  logic [REG_W-1:0] sts_wdata,
  input  logic             plug_req,
  input  logic             unplug_req,
  input  logic             cold_plug,
  input  logic             btn_press,
  output logic [REG_W-1:0] ctl_q,
  output logic [REG_W-1:0] sts_q,
  output logic             eval_q,
  output logic             clr_q,
  output logic             busy_q
);
  logic [REG_W-1:0] ctl_n, sts_n, sts_cleared, evt_set;
  logic             refused, accept_plug, accept_unplug;

  assign refused       = (plug_req | unplug_req) & sts_q[ST_LOCK];
  assign accept_plug   = plug_req & ~sts_q[ST_LOCK];
  assign accept_unplug = unplug_req & ~plug_req & ~sts_q[ST_LOCK];

  always_comb begin
    ctl_n       = ctl_q;
    sts_cleared = sts_q;
    if (sts_wr) sts_cleared = sts_q & ~(sts_wdata & EVT_MASK);
    sts_n   = sts_cleared;
    evt_set = '0;
    if (ctl_wr) begin
      ctl_n            = ctl_wdata & CTL_WMASK;
      evt_set[ST_CDON] = 1'b1;
      if (ctl_wdata[CT_LCTL]) sts_n[ST_LOCK] = ~sts_q[ST_LOCK];
    end
    if (cold_plug) begin
      sts_n[ST_PRES] = 1'b1;
    end else if (accept_plug) begin
      sts_n[ST_PRES]   = 1'b1;
      evt_set[ST_PCHG] = 1'b1;
    end else if (accept_unplug) begin
      sts_n[ST_PRES]   = 1'b0;
      evt_set[ST_PCHG] = 1'b1;
    end
    if (btn_press) evt_set[ST_BTN] = 1'b1;
    sts_n = sts_n | evt_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= CTL_RST;
      sts_q  <= '0;
      eval_q <= 1'b0;
      clr_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_n;
      sts_q  <= sts_n;
      eval_q <= ctl_wr | (|(evt_set & ~sts_cleared));
      clr_q  <= sts_wr;
      busy_q <= refused;
    end
  end

  // R4
  cdone_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> sts_q[ST_CDON]);
  // R5
  lock_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[CT_LCTL]) |=> (sts_q[ST_LOCK] != $past(sts_q[ST_LOCK])));
  // R7
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> $past(sts_q[ST_LOCK] && (plug_req || unplug_req)));
  // R2
  cold_pres_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cold_plug && !ctl_wr) |=> (sts_q[ST_PRES] && $stable(sts_q[ST_LOCK])));
endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
  import hp_slot_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] ctl_q,
  input  logic [REG_W-1:0] sts_q,
  input  logic             eval_q,
  input  logic             clr_q,
  input  logic             msix_en,
  input  logic             msi_en,
  input  logic [VEC_W-1:0] msg_num,
  output logic             msg_req,
  output logic [VEC_W-1:0] msg_vec,
  output logic             msg_is_msix,
  output logic             intx
);
  logic cond, msg_mode;
  logic notified_q, notified_n, intx_n, req_n;

  assign cond     = ctl_q[CT_HPIE] & (|(sts_q & ctl_q & EVT_MASK));
  assign msg_mode = msix_en | msi_en;

  always_comb begin
    notified_n = notified_q;
    intx_n     = intx;
    req_n      = 1'b0;
    if (eval_q) begin
      if (cond != notified_q) begin
        notified_n = cond;
        if (msg_mode) req_n  = 1'b1;
        else          intx_n = cond;
      end
    end else if (clr_q) begin
      notified_n = cond;
      if (!msg_mode && !cond) intx_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      notified_q  <= 1'b0;
      intx        <= 1'b0;
      msg_req     <= 1'b0;
      msg_vec     <= '0;
      msg_is_msix <= 1'b0;
    end else begin
      notified_q <= notified_n;
      intx       <= intx_n;
      msg_req    <= req_n;
      if (req_n) begin
        msg_vec     <= msg_num;
        msg_is_msix <= msix_en;
      end
    end
  end

  // R10
  msg_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |-> $past(msix_en || msi_en));
  // R6
  intx_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intx) |-> $past(!(msix_en || msi_en) && eval_q));
  // R10
  msix_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_req && msg_is_msix) |-> $past(msix_en));
endmodule

// File: rtl/hp_slot_ctl.sv
module hp_slot_ctl
  import hp_slot_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [REG_W-1:0] ctl_wdata,
  input  logic             sts_wr,
  input  logic [REG_W-1:0] sts_wdata,
  input  logic             plug_req,
  input  logic             unplug_req,
  input  logic             cold_plug,
  input  logic             btn_press,
  input  logic             msix_en,
  input  logic             msi_en,
  input  logic [VEC_W-1:0] msg_num,
  output logic [REG_W-1:0] ctl_rd,
  output logic [REG_W-1:0] sts_rd,
  output logic             busy,
  output logic             msg_req,
  output logic [VEC_W-1:0] msg_vec,
  output logic             msg_is_msix,
  output logic             intx
);
  logic [REG_W-1:0] ctl_q, sts_q;
  logic             eval_q, clr_q;

  hp_slot_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .plug_req(plug_req), .unplug_req(unplug_req),
    .cold_plug(cold_plug), .btn_press(btn_press),
    .ctl_q(ctl_q), .sts_q(sts_q),
    .eval_q(eval_q), .clr_q(clr_q), .busy_q(busy)
  );

  hp_slot_notify #(.VEC_W(VEC_W)) u_notify (
    .clk(clk), .rst_n(rst_n),
    .ctl_q(ctl_q), .sts_q(sts_q),
    .eval_q(eval_q), .clr_q(clr_q),
    .msix_en(msix_en), .msi_en(msi_en), .msg_num(msg_num),
    .msg_req(msg_req), .msg_vec(msg_vec),
    .msg_is_msix(msg_is_msix), .intx(intx)
  );

  assign ctl_rd = ctl_q;
  assign sts_rd = sts_q;
endmodule

// File: tb/hp_slot_ctl_test.sv
module hp_slot_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0, sts_wr = 1'b0;
  logic [15:0] ctl_wdata = '0, sts_wdata = '0;
  logic        plug_req = 1'b0, unplug_req = 1'b0, cold_plug = 1'b0, btn_press = 1'b0;
  logic        msix_en = 1'b0, msi_en = 1'b0;
  logic [4:0]  msg_num = 5'd19;
  logic [15:0] ctl_rd, sts_rd;
  logic        busy, msg_req, msg_is_msix, intx;
  logic [4:0]  msg_vec;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [5:0] exp_q[$];

  always #2 clk = ~clk;

  hp_slot_ctl uut (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .plug_req(plug_req), .unplug_req(unplug_req),
    .cold_plug(cold_plug), .btn_press(btn_press),
    .msix_en(msix_en), .msi_en(msi_en), .msg_num(msg_num),
    .ctl_rd(ctl_rd), .sts_rd(sts_rd), .busy(busy),
    .msg_req(msg_req), .msg_vec(msg_vec),
    .msg_is_msix(msg_is_msix), .intx(intx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop expected messages as they appear
  always @(negedge clk) begin
    if (rst_n && msg_req) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R10 unexpected message actual=%h expected=none", {msg_is_msix, msg_vec});
      end else begin
        logic [5:0] e;
        e = exp_q.pop_front();
        if ({msg_is_msix, msg_vec} !== e) begin
          n_bad++;
          $display("FAIL R10 message actual=%h expected=%h", {msg_is_msix, msg_vec}, e);
        end
      end
    end
  end

  task automatic wr(input logic c, input logic [15:0] cd, input logic s, input logic [15:0] sd);
    @(negedge clk);
    ctl_wr = c; ctl_wdata = cd; sts_wr = s; sts_wdata = sd;
    @(negedge clk);
    ctl_wr = 1'b0; sts_wr = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: plug_req = 1'b1;
      1: unplug_req = 1'b1;
      2: cold_plug = 1'b1;
      default: btn_press = 1'b1;
    endcase
    @(negedge clk);
    plug_req = 1'b0; unplug_req = 1'b0; cold_plug = 1'b0; btn_press = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctl", ctl_rd, 16'h03C0);
    chk("R1 sts", sts_rd, 0);
    chk("R1 outs", {intx, msg_req, busy}, 0);
    // R2 cold plug
    pulse(2);
    chk("R2 sts", sts_rd, 16'h0040);
    // R3 R4 R5 full control write
    wr(1, 16'hFFFF, 0, 0);
    chk("R3 ctl mask", ctl_rd, 16'h03F9);
    chk("R4 R5 sts", sts_rd, 16'h00D0);
    @(negedge clk);
    chk("R6 intx rise", intx, 1);
    // R7 refused while locked
    pulse(0);
    chk("R7 busy", busy, 1);
    chk("R7 sts", sts_rd, 16'h00D0);
    // R8 clear command done
    wr(0, 0, 1, 16'h0010);
    chk("R8 sts", sts_rd, 16'h00C0);
    @(negedge clk);
    chk("R8 intx drop", intx, 0);
    // R5 second toggle unlocks
    wr(1, 16'h0839, 0, 0);
    chk("R5 unlock", sts_rd, 16'h0050);
    @(negedge clk);
    chk("R6 intx again", intx, 1);
    wr(0, 0, 1, 16'h0010);
    @(negedge clk);
    chk("R8 intx low", intx, 0);
    // R9 R10 unplug in extended-message mode
    msix_en = 1'b1;
    exp_q.push_back({1'b1, 5'd19});
    pulse(1);
    chk("R9 unplug sts", sts_rd, 16'h0008);
    repeat (2) @(negedge clk);
    chk("R10 no intx", intx, 0);
    // R11 button while condition already true: no message
    pulse(3);
    chk("R11 btn sts", sts_rd, 16'h0009);
    pulse(3);
    repeat (2) @(negedge clk);
    // R8 R10 clear all, both modes on, press again
    wr(0, 0, 1, 16'h0019);
    chk("R8 clr all", sts_rd, 0);
    msi_en = 1'b1;
    exp_q.push_back({1'b1, 5'd19});
    pulse(3);
    repeat (2) @(negedge clk);
    // R10 plain-message only
    msix_en = 1'b0;
    msg_num = 5'd7;
    wr(0, 0, 1, 16'h0001);
    exp_q.push_back({1'b0, 5'd7});
    pulse(3);
    repeat (2) @(negedge clk);
    // R9 plug accepted
    pulse(0);
    chk("R9 plug sts", sts_rd, 16'h0049);
    chk("R7 no busy", busy, 0);
    repeat (2) @(negedge clk);
    // R12 drop interrupt enable: falling change sends message
    exp_q.push_back({1'b0, 5'd7});
    wr(1, 16'h0019, 0, 0);
    repeat (2) @(negedge clk);
    wr(0, 0, 1, 16'h0019);
    pulse(3);
    repeat (3) @(negedge clk);
    chk("R12 queue drained", exp_q.size(), 0);
    msi_en = 1'b0;
    pulse(1);
    repeat (2) @(negedge clk);
    chk("R12 intx gated", intx, 0);
    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R1 ctl again", ctl_rd, 16'h03C0);
    chk("R1 sts again", sts_rd, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 leftover", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule